// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block sequences the bus cycle of a small 8-bit processor and stretches accesses to slow external devices. Each bus cycle walks through four bus states, T1 to T4. Between T3 and T4 it can hold the bus in a wait state for a programmable number of extra states. The block's clock `clk` ticks once per bus state, which is half a period of the processor's bus clock. One wait state therefore also lasts one tick.

A 3-bit wait setting selects the stretch in steps of two states, from none up to fourteen. The setting and the target qualifiers are captured when an access is accepted. Changing them while a cycle is running only affects the next access. No wait states are added when the access goes to an internal register or internal memory. None are added either while the chip runs from its low-speed oscillator. So in single-chip operation, where every access is internal, the setting has no effect.

The interface is control only and carries no data stream. `start` is a plain strobe that is taken only while the sequencer is idle. `cycle_done` marks the final bus state of each access.

Top module: `bus_wait_seq`

## Requirements
- R1: For an external access with normal clocking, the number of wait states equals twice the value of `wait_sel`: 000 gives none, 001 gives 2, 010 gives 4, and so on up to 111, which gives 14.
- R2: `bus_state` is encoded as idle=0, T1=1, T2=2, T3=3, wait=4, T4=5. An accepted access runs T1, T2, T3, then every wait state, then T4, and then returns to idle. `wait_active` is high exactly in the wait states.
- R3: When `tgt_internal` is high at acceptance, no wait state is inserted whatever `wait_sel` is, and T4 directly follows T3.
- R4: When `slow_osc` is high at acceptance, no wait state is inserted whatever `wait_sel` is.
- R5: `wait_sel`, `tgt_internal` and `slow_osc` are sampled only on the clock edge that accepts `start`. Changes during a running cycle do not alter that cycle's length.
- R6: `start` is accepted only while `bus_state` is idle. If it is high during a running cycle, that cycle is neither restarted nor altered.
- R7: `cycle_done` is high for exactly one tick, the T4 tick of each access, and is low otherwise.
- R8: While `rst_n` is low, or right after it is asserted, `bus_state` is idle, `wait_active` and `cycle_done` are low, and the captured setting is cleared to 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock, one rising edge per bus state (half a bus clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_sel | input | 3 | Wait setting, captured at acceptance |
| start | input | 1 | Access request strobe, taken only when idle |
| tgt_internal | input | 1 | Access targets internal register or memory |
| slow_osc | input | 1 | Chip is clocked from the low-speed oscillator |
| bus_state | output | 3 | Current bus state (encoding in R2) |
| wait_active | output | 1 | High during inserted wait states |
| cycle_done | output | 1 | High during the T4 state |

## Verification
When `start` is accepted at edge k, `bus_state` shows T1 after edge k, T3 after edge k+2 and the first wait state after edge k+3. T4, with `cycle_done` high, follows after edge k+3+N, where N is the wait count, and idle returns after edge k+4+N. The bench drives inputs on the falling edge and updates its reference model on the rising edge. It compares all three outputs 1 ns after every rising edge, so each expected value is checked in the tick where it becomes due. It also totals the wait ticks of each access and compares that total with the count derived from the setting captured at acceptance.

// File: rtl/bus_wait_seq_pkg.sv
package bus_wait_seq_pkg;
  localparam int PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;
endpackage

// File: rtl/bws_setting_latch.sv
module bws_setting_latch #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             internal_in,
  input  logic             slow_in,
  output logic [SEL_W-1:0] sel_q,
  output logic             suppress_q
);
  // Captured only when a new access is taken; held for the whole cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= '0;
      suppress_q <= 1'b0;
    end else if (accept) begin
      sel_q      <= sel_in;
      suppress_q <= internal_in | slow_in;
    end
  end
endmodule

// File: rtl/bws_wait_calc.sv
module bws_wait_calc #(
  parameter int SEL_W     = 3,
  parameter int WAIT_STEP = 2,
  parameter int CNT_W     = SEL_W + $clog2(WAIT_STEP) + 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             suppress,
  output logic [CNT_W-1:0] need,
  output logic             need_zero
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(WAIT_STEP);

  always_comb begin
    if (suppress) need = '0;
    else          need = CNT_W'(sel) * STEP;
    need_zero = (need == '0);
  end
endmodule

// File: rtl/bws_wait_counter.sv
module bws_wait_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] need,
  output logic             last
);
  logic [CNT_W-1:0] rem_q;

  // rem_q holds the wait ticks still to come after the current one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= (need == '0) ? '0 : need - CNT_W'(1);
    end else if (dec && rem_q != '0) begin
      rem_q <= rem_q - CNT_W'(1);
    end
  end

  assign last = (rem_q == '0);
endmodule

// File: rtl/bws_phase_fsm.sv
module bws_phase_fsm
  import bus_wait_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   need_zero,
  input  logic   wait_last,
  output phase_e phase,
  output logic   accept
);
  phase_e nxt;

  assign accept = (phase == PH_IDLE) && start;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (start) nxt = PH_T1;
      PH_T1:   nxt = PH_T2;
      PH_T2:   nxt = PH_T3;
      PH_T3:   nxt = need_zero ? PH_T4 : PH_TW;
      PH_TW:   if (wait_last) nxt = PH_T4;
      PH_T4:   nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
  import bus_wait_seq_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int WAIT_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] wait_sel,
  input  logic             start,
  input  logic             tgt_internal,
  input  logic             slow_osc,
  output logic [2:0]       bus_state,
  output logic             wait_active,
  output logic             cycle_done
);
  localparam int CNT_W = SEL_W + $clog2(WAIT_STEP) + 1;

  phase_e           phase;
  logic             accept;
  logic [SEL_W-1:0] sel_q;
  logic             suppress_q;
  logic [CNT_W-1:0] need;
  logic             need_zero;
  logic             wait_last;

  bws_setting_latch #(.SEL_W(SEL_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .sel_in(wait_sel), .internal_in(tgt_internal), .slow_in(slow_osc),
    .sel_q(sel_q), .suppress_q(suppress_q)
  );

  bws_wait_calc #(.SEL_W(SEL_W), .WAIT_STEP(WAIT_STEP), .CNT_W(CNT_W)) u_calc (
    .sel(sel_q), .suppress(suppress_q), .need(need), .need_zero(need_zero)
  );

  bws_wait_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(phase == PH_T3), .dec(phase == PH_TW),
    .need(need), .last(wait_last)
  );

  bws_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .need_zero(need_zero), .wait_last(wait_last),
    .phase(phase), .accept(accept)
  );

  assign bus_state   = phase;
  assign wait_active = (phase == PH_TW);
  assign cycle_done  = (phase == PH_T4);
endmodule

// File: rtl/bus_wait_seq_checker.sv
module bus_wait_seq_checker #(
  parameter int SEL_W = 3,
  parameter int WAIT_STEP = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] wait_sel,
  input logic             start,
  input logic             tgt_internal,
  input logic             slow_osc,
  input logic [2:0]       bus_state,
  input logic             wait_active,
  input logic             cycle_done
);
  localparam int CW = SEL_W + $clog2(WAIT_STEP) + 2;
  logic [CW-1:0] exp_q, seen_q;
  logic          supp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0; seen_q <= '0; supp_q <= 1'b0;
    end else begin
      if (start && bus_state == 3'd0) begin
        supp_q <= tgt_internal | slow_osc;
        exp_q  <= (tgt_internal | slow_osc) ? '0 : CW'(wait_sel) * CW'(WAIT_STEP);
      end
      if (bus_state == 3'd1)      seen_q <= '0;
      else if (wait_active)       seen_q <= seen_q + CW'(1);
    end
  end

  p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> seen_q == exp_q);
  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 3'd3 |=> (bus_state == 3'd4 || bus_state == 3'd5));
  p_wait_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 3'd4 |=> (bus_state == 3'd4 || bus_state == 3'd5));
  p_nowait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (supp_q && bus_state == 3'd3) |=> bus_state == 3'd5);
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state != 3'd0 |=> bus_state != 3'd1);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !cycle_done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> bus_state == 3'd0);
endmodule

bind bus_wait_seq bus_wait_seq_checker #(.SEL_W(SEL_W), .WAIT_STEP(WAIT_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wait_sel(wait_sel), .start(start),
  .tgt_internal(tgt_internal), .slow_osc(slow_osc),
  .bus_state(bus_state), .wait_active(wait_active), .cycle_done(cycle_done)
);

// File: tb/bus_wait_seq_test.sv
module bus_wait_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] wait_sel = 3'd0;
  logic       start = 1'b0;
  logic       tgt_internal = 1'b0;
  logic       slow_osc = 1'b0;
  logic [2:0] bus_state;
  logic       wait_active;
  logic       cycle_done;

  int checks = 0;
  int failures = 0;
  int m_state = 0;
  int m_need = 0;
  int m_left = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_wait_seq uut (
    .clk(clk), .rst_n(rst_n), .wait_sel(wait_sel), .start(start),
    .tgt_internal(tgt_internal), .slow_osc(slow_osc),
    .bus_state(bus_state), .wait_active(wait_active), .cycle_done(cycle_done)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: one state per rising edge.
  task automatic model_step(input bit st, input int sel, input bit in_i, input bit sl);
    case (m_state)
      0: if (st) begin m_state = 1; m_need = (in_i || sl) ? 0 : 2 * sel; end
      1: m_state = 2;
      2: m_state = 3;
      3: if (m_need == 0) m_state = 5; else begin m_state = 4; m_left = m_need; end
      4: begin m_left--; if (m_left == 0) m_state = 5; end
      5: m_state = 0;
      default: m_state = 0;
    endcase
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic tick(input bit st, input int sel, input bit in_i, input bit sl);
    start = st; wait_sel = 3'(sel); tgt_internal = in_i; slow_osc = sl;
    @(posedge clk);
    model_step(st, sel, in_i, sl);
    #1;
    check("R2 bus_state", int'(bus_state), m_state);
    check("R2 wait_active", int'(wait_active), int'(m_state == 4));
    check("R7 cycle_done", int'(cycle_done), int'(m_state == 5));
    @(negedge clk);
  endtask

  // One access; setting inputs switch to the *_mid values after acceptance.
  task automatic access(input string tag, input int sel, input bit in_i, input bit sl,
                        input int sel_mid, input bit in_mid, input bit sl_mid,
                        input bit hold_start);
    int waits = 0;
    int busy = 0;
    int exp = (in_i || sl) ? 0 : 2 * sel;
    tick(1'b1, sel, in_i, sl);
    busy++;
    for (int g = 0; g < 40 && m_state != 0; g++) begin
      tick(hold_start, sel_mid, in_mid, sl_mid);
      if (wait_active) waits++;
      if (bus_state != 3'd0) busy++;
    end
    check(tag, waits, exp);
    check({tag, " busy length"}, busy, 4 + exp);
    if (hold_start) begin
      tick(1'b0, 0, 1'b0, 1'b0);
      while (m_state != 0) tick(1'b0, 0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 reset bus_state", int'(bus_state), 0);
    check("R8 reset wait_active", int'(wait_active), 0);
    check("R8 reset cycle_done", int'(cycle_done), 0);
    rst_n = 1'b1;
    tick(1'b0, 7, 1'b0, 1'b0);

    // R1: every setting, external access, fast clock
    for (int s = 0; s < 8; s++) begin
      access("R1 wait count", s, 1'b0, 1'b0, s, 1'b0, 1'b0, 1'b0);
      tick(1'b0, 0, 1'b0, 1'b0);
    end
    // R3: internal target suppresses
    access("R3 internal no wait", 7, 1'b1, 1'b0, 7, 1'b1, 1'b0, 1'b0);
    access("R3 internal no wait sel3", 3, 1'b1, 1'b0, 3, 1'b1, 1'b0, 1'b0);
    // R4: slow oscillator suppresses
    access("R4 slow osc no wait", 5, 1'b0, 1'b1, 5, 1'b0, 1'b1, 1'b0);
    access("R4 slow osc and internal", 6, 1'b1, 1'b1, 6, 1'b1, 1'b1, 1'b0);
    // R5: mid-cycle changes ignored
    access("R5 sel change mid", 2, 1'b0, 1'b0, 7, 1'b0, 1'b0, 1'b0);
    access("R5 flags rise mid", 4, 1'b0, 1'b0, 4, 1'b1, 1'b1, 1'b0);
    access("R5 flags fall mid", 6, 1'b1, 1'b0, 6, 1'b0, 1'b0, 1'b0);
    // R6: start held through a running cycle
    access("R6 start held", 3, 1'b0, 1'b0, 1, 1'b0, 1'b0, 1'b1);
    access("R6 start held long", 7, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b1);

    // R8: reset during wait states clears the cycle
    tick(1'b1, 7, 1'b0, 1'b0);
    repeat (5) tick(1'b0, 7, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R8 async reset bus_state", int'(bus_state), 0);
    check("R8 async reset wait_active", int'(wait_active), 0);
    check("R8 async reset cycle_done", int'(cycle_done), 0);
    m_state = 0; m_need = 0; m_left = 0;
    @(negedge clk);
    rst_n = 1'b1;
    tick(1'b0, 0, 1'b0, 1'b0);
    access("R8 access after reset", 1, 1'b0, 1'b0, 1, 1'b0, 1'b0, 1'b0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule